// File: doc/BRIEF.md
# Discontinuous Space-Vector Gate Sequencer

This block drives the nine gates of a three-phase two-level bridge. Besides the six leg switches, the bridge has a series switch on the DC side and a pair of switched-capacitor switches. Once per switching period the block samples a sector number and two active-vector dwell times, both given in clock cycles. It then plays a symmetric six-segment pattern. The pattern starts and ends with the all-upper zero vector and holds the two active vectors of the sector in the middle.

Each vector is turned into gate levels. Every leg and the capacitor-switch pair pass through a dead-time stage, so a switch can turn on only after its partner has been off for a programmable number of cycles. The series switch isolates the bridge from the DC side during the zero vector. The capacitor switches follow the number of upper switches that are on: one upper switch (odd vector) or more than one (even vector or zero vector). A fault input clears every gate at the next clock edge, while the pattern timing keeps running.

Top module: `dpwm_gate_seq`

## Requirements
- R1: A period consists of six segments in this order: zero, X, Y, Y, X, zero. The segment lengths are floor(Tz/2), floor(Tx/2), floor(Ty/2), floor(Ty/2), floor(Tx/2), and the final zero segment takes every remaining cycle of the period. Here Tz = period - Tx - Ty.
- R2: The leg states (X, Y) for each sector are: 1:(110,100), 2:(110,010), 3:(011,010), 4:(011,001), 5:(101,001), 6:(101,100). Bit 2 is phase A, bit 1 is phase B and bit 0 is phase C.
- R3: The only zero vector is 111, and state 000 is never produced. A sector value of 0 or 7 gives the zero vector for the whole period.
- R4: Sector, period and dwell times are sampled only at the start of a period. A change in the middle of a period has no effect until the next period. A period input below 2 is treated as 2.
- R5: Tx is limited to the period, and Ty is limited to the period minus the limited Tx, so Tz is never negative.
- R6: For each leg, a vector bit of 1 requests the upper gate (g_hi) and a bit of 0 requests the lower gate (g_lo).
- R7: The odd capacitor switch (g_odd) is requested for the vectors 100, 010 and 001. The even switch (g_even) is requested for the vectors 110, 011, 101 and 111.
- R8: The series switch (g_ser) is on during every active vector and off during the zero vector.
- R9: When the request of a switch pair changes, both switches stay off for max(dead_i,1) cycles before the newly requested switch turns on. The two switches of a pair are never on together.
- R10: When fault is high at a clock edge, all nine gates are off after that edge. The period timing continues through the fault.
- R11: cycle_start is high in exactly the first cycle of each period, and that cycle lines up with the gate outputs of the first segment.
- R12: While reset is held, all gates and cycle_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fault | input | 1 | Forces all gates off |
| sector_i | input | 3 | Sector number, 1 to 6 |
| period_i | input | CNT_W | Switching period in cycles |
| tx_i | input | CNT_W | Dwell of the first active vector X |
| ty_i | input | CNT_W | Dwell of the second active vector Y |
| dead_i | input | DEAD_W | Dead time in cycles |
| cycle_start | output | 1 | First cycle of a period |
| g_hi | output | 3 | Upper leg gates, bit 2 = phase A |
| g_lo | output | 3 | Lower leg gates, bit 2 = phase A |
| g_ser | output | 1 | DC-side series switch |
| g_odd | output | 1 | Capacitor switch for odd vectors |
| g_even | output | 1 | Capacitor switch for even and zero vectors |

## Verification
The bench sweeps all six sectors with even dwell times; the gate patterns there show whether the X/Y table and the leg, parity and series decoding are correct. Odd dwell times and a zero-length zero segment show where the remainder cycles go. Over-range dwell times exercise the clamping, and sectors 0 and 7 exercise the fallback to the zero vector. Changing the inputs in the middle of a period shows that sampling happens only at period start, runs with dead times of 0 and 5 show the dead-time gap, and a fault pulse shows the forced-off path.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    typedef logic [2:0] vec3_t;

    localparam vec3_t ZERO_VEC = 3'b111;

    // Returns {X, Y} for a sector; unknown sectors play the zero vector only.
    function automatic logic [5:0] sector_vecs(input logic [2:0] sec);
        logic [5:0] r;
        case (sec)
            3'd1:    r = {3'b110, 3'b100};
            3'd2:    r = {3'b110, 3'b010};
            3'd3:    r = {3'b011, 3'b010};
            3'd4:    r = {3'b011, 3'b001};
            3'd5:    r = {3'b101, 3'b001};
            3'd6:    r = {3'b101, 3'b100};
            default: r = {ZERO_VEC, ZERO_VEC};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dpwm_seq.sv
module dpwm_seq
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sector_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] tx_i,
    input  logic [CNT_W-1:0] ty_i,
    output vec3_t            vec_o,
    output logic             start_o
);

    localparam logic [CNT_W-1:0] MIN_P = CNT_W'(2);

    typedef struct packed {
        logic             run;
        logic             start;
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] plen;
        logic [CNT_W-1:0] b0;
        logic [CNT_W-1:0] b1;
        logic [CNT_W-1:0] b2;
        logic [CNT_W-1:0] b3;
        logic [CNT_W-1:0] b4;
        vec3_t            vx;
        vec3_t            vy;
        vec3_t            vec;
    } seq_t;

    seq_t s_d, s_q;
    logic             latch;
    logic [CNT_W-1:0] p_len, tx_c, rem_c, ty_c, tz_c;

    always_comb begin
        s_d   = s_q;
        latch = !s_q.run || (s_q.pos == s_q.plen - 1'b1);
        p_len = (period_i < MIN_P) ? MIN_P : period_i;
        tx_c  = (tx_i > p_len) ? p_len : tx_i;
        rem_c = p_len - tx_c;
        ty_c  = (ty_i > rem_c) ? rem_c : ty_i;
        tz_c  = rem_c - ty_c;
        if (latch) begin
            s_d.run          = 1'b1;
            s_d.pos          = '0;
            s_d.plen         = p_len;
            s_d.b0           = tz_c >> 1;
            s_d.b1           = s_d.b0 + (tx_c >> 1);
            s_d.b2           = s_d.b1 + (ty_c >> 1);
            s_d.b3           = s_d.b2 + (ty_c >> 1);
            s_d.b4           = s_d.b3 + (tx_c >> 1);
            {s_d.vx, s_d.vy} = sector_vecs(sector_i);
        end else begin
            s_d.pos = s_q.pos + 1'b1;
        end
        s_d.start = latch;
        if (s_d.pos < s_d.b0)      s_d.vec = ZERO_VEC;
        else if (s_d.pos < s_d.b1) s_d.vec = s_d.vx;
        else if (s_d.pos < s_d.b2) s_d.vec = s_d.vy;
        else if (s_d.pos < s_d.b3) s_d.vec = s_d.vy;
        else if (s_d.pos < s_d.b4) s_d.vec = s_d.vx;
        else                       s_d.vec = ZERO_VEC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.vec <= ZERO_VEC;
        end else begin
            s_q <= s_d;
        end
    end

    assign vec_o   = s_q.vec;
    assign start_o = s_q.start;

    p_no_null_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.vec != 3'b000));

    p_pos_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.pos < s_q.plen));

endmodule

// File: rtl/dpwm_decode.sv
module dpwm_decode
    import dpwm_pkg::*;
(
    input  vec3_t      vec_i,
    output logic [2:0] want_leg,
    output logic       want_odd,
    output logic       want_ser
);

    always_comb begin
        want_leg = vec_i;
        want_odd = ($countones(vec_i) == 1);
        want_ser = (vec_i != ZERO_VEC);
    end

endmodule

// File: rtl/dpwm_dead.sv
module dpwm_dead #(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              want_hi,
    input  logic [DEAD_W-1:0] dead_i,
    output logic              hi_o,
    output logic              lo_o
);

    typedef struct packed {
        logic              side;
        logic              hi;
        logic              lo;
        logic [DEAD_W-1:0] wait_cnt;
    } dead_t;

    dead_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (fault) begin
            d_d.side     = want_hi;
            d_d.hi       = 1'b0;
            d_d.lo       = 1'b0;
            d_d.wait_cnt = '0;
        end else if (want_hi != d_q.side) begin
            d_d.side     = want_hi;
            d_d.hi       = 1'b0;
            d_d.lo       = 1'b0;
            d_d.wait_cnt = dead_i;
        end else if (d_q.wait_cnt > 1) begin
            d_d.hi       = 1'b0;
            d_d.lo       = 1'b0;
            d_d.wait_cnt = d_q.wait_cnt - 1'b1;
        end else begin
            d_d.hi       = d_q.side;
            d_d.lo       = !d_q.side;
            d_d.wait_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign hi_o = d_q.hi;
    assign lo_o = d_q.lo;

    p_gap_before_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_q.hi) |-> !$past(d_q.lo));

    p_gap_before_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_q.lo) |-> !$past(d_q.hi));

    p_fault_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!d_q.hi && !d_q.lo));

endmodule

// File: rtl/dpwm_gate_seq.sv
module dpwm_gate_seq
    import dpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic [2:0]        sector_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  tx_i,
    input  logic [CNT_W-1:0]  ty_i,
    input  logic [DEAD_W-1:0] dead_i,
    output logic              cycle_start,
    output logic [2:0]        g_hi,
    output logic [2:0]        g_lo,
    output logic              g_ser,
    output logic              g_odd,
    output logic              g_even
);

    localparam int NPAIR = 4;

    typedef struct packed {
        logic ser;
        logic start;
    } top_t;

    vec3_t            vec;
    logic             seq_start;
    logic [2:0]       want_leg;
    logic             want_odd, want_ser;
    logic [NPAIR-1:0] want_pair, hi_v, lo_v;
    top_t             t_d, t_q;

    dpwm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sector_i (sector_i),
        .period_i (period_i),
        .tx_i     (tx_i),
        .ty_i     (ty_i),
        .vec_o    (vec),
        .start_o  (seq_start)
    );

    dpwm_decode u_dec (
        .vec_i    (vec),
        .want_leg (want_leg),
        .want_odd (want_odd),
        .want_ser (want_ser)
    );

    assign want_pair = {want_odd, want_leg};

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        dpwm_dead #(.DEAD_W(DEAD_W)) u_dead (
            .clk     (clk),
            .rst_n   (rst_n),
            .fault   (fault),
            .want_hi (want_pair[i]),
            .dead_i  (dead_i),
            .hi_o    (hi_v[i]),
            .lo_o    (lo_v[i])
        );
    end

    always_comb begin
        t_d       = t_q;
        t_d.ser   = want_ser && !fault;
        t_d.start = seq_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign cycle_start = t_q.start;
    assign g_ser       = t_q.ser;
    assign g_hi        = hi_v[2:0];
    assign g_lo        = lo_v[2:0];
    assign g_odd       = hi_v[3];
    assign g_even      = lo_v[3];

    p_odd_needs_ser_r8: assert property (@(posedge clk) disable iff (!rst_n)
        g_odd |-> g_ser);

    p_fault_ser_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !g_ser);

endmodule

// File: tb/dpwm_gate_seq_tb.sv
module dpwm_gate_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int DEAD_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fault = 1'b0;
    logic [2:0]        sector_i = 3'd1;
    logic [CNT_W-1:0]  period_i = 16'd40;
    logic [CNT_W-1:0]  tx_i = 16'd10;
    logic [CNT_W-1:0]  ty_i = 16'd8;
    logic [DEAD_W-1:0] dead_i = 8'd2;
    logic              cycle_start;
    logic [2:0]        g_hi, g_lo;
    logic              g_ser, g_odd, g_even;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dpwm_gate_seq #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .fault(fault), .sector_i(sector_i),
        .period_i(period_i), .tx_i(tx_i), .ty_i(ty_i), .dead_i(dead_i),
        .cycle_start(cycle_start), .g_hi(g_hi), .g_lo(g_lo),
        .g_ser(g_ser), .g_odd(g_odd), .g_even(g_even)
    );

    function automatic logic [2:0] exp_vec(int c, int p_in, int sec, int tx_in, int ty_in);
        int p, tx, ty, tz, e0, e1, e2, e3, e4;
        logic [2:0] vx, vy;
        p  = (p_in < 2) ? 2 : p_in;
        tx = (tx_in > p) ? p : tx_in;
        ty = (ty_in > p - tx) ? p - tx : ty_in;
        tz = p - tx - ty;
        e0 = tz / 2; e1 = e0 + tx / 2; e2 = e1 + ty / 2;
        e3 = e2 + ty / 2; e4 = e3 + tx / 2;
        case (sec)
            1: begin vx = 3'b110; vy = 3'b100; end
            2: begin vx = 3'b110; vy = 3'b010; end
            3: begin vx = 3'b011; vy = 3'b010; end
            4: begin vx = 3'b011; vy = 3'b001; end
            5: begin vx = 3'b101; vy = 3'b001; end
            6: begin vx = 3'b101; vy = 3'b100; end
            default: begin vx = 3'b111; vy = 3'b111; end
        endcase
        if (c < e0) return 3'b111;
        if (c < e1) return vx;
        if (c < e3) return vy;
        if (c < e4) return vx;
        return 3'b111;
    endfunction

    // bit i<3: leg request; bit 3: odd-switch request
    function automatic logic [3:0] wants(logic [2:0] v);
        return {($countones(v) == 1), v};
    endfunction

    task automatic check(string req, logic [9:0] act, logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] outs();
        return {cycle_start, g_ser, g_hi, g_lo, g_odd, g_even};
    endfunction

    task automatic wait_start();
        @(negedge clk);
        while (!cycle_start) @(negedge clk);
    endtask

    task automatic apply(int p, int sec, int tx, int ty, int dt);
        period_i = CNT_W'(p); sector_i = 3'(sec);
        tx_i = CNT_W'(tx); ty_i = CNT_W'(ty); dead_i = DEAD_W'(dt);
    endtask

    // Checks one full period against (p,sec,tx,ty); optional mid-period input change (R4).
    task automatic check_period(string req, int p, int sec, int tx, int ty, int dt,
                                bit mid, int p2, int sec2, int tx2, int ty2);
        int pe, dm;
        int age [4];
        logic [3:0] last, w;
        logic [2:0] v;
        logic [9:0] e;
        pe = (p < 2) ? 2 : p;
        dm = (dt < 1) ? 1 : dt;
        apply(p, sec, tx, ty, dt);
        wait_start(); wait_start(); wait_start();
        last = wants(exp_vec(pe - 1, p, sec, tx, ty));
        for (int k = 0; k < 4; k++) age[k] = 1000;
        for (int c = 0; c < 2 * pe; c++) begin
            v = exp_vec(c % pe, p, sec, tx, ty);
            w = wants(v);
            for (int k = 0; k < 4; k++) begin
                if (w[k] != last[k]) begin age[k] = 0; last[k] = w[k]; end
                else age[k]++;
            end
            if (c >= pe) begin
                e[9] = (c == pe);
                e[8] = (v != 3'b111);
                for (int k = 0; k < 3; k++) begin
                    e[5 + k] = (age[k] >= dm) && w[k];
                    e[2 + k] = (age[k] >= dm) && !w[k];
                end
                e[1] = (age[3] >= dm) && w[3];
                e[0] = (age[3] >= dm) && !w[3];
                check(req, outs(), e);
                if (mid && c == pe + 5) apply(p2, sec2, tx2, ty2, dt);
                @(negedge clk);
            end
        end
        n_chk++;
        if (cycle_start !== 1'b1) begin
            n_bad++;
            $display("FAIL R11 period length: actual cycle_start %b expected 1", cycle_start);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 reset", outs(), 10'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_sectors();
        for (int s = 1; s <= 6; s++)
            check_period("R1 R2 R6 R7 R8 sector sweep", 40, s, 10, 8, 2, 0, 0, 0, 0, 0);
    endtask

    task automatic t_remainder();
        check_period("R1 odd remainder", 41, 3, 11, 7, 2, 0, 0, 0, 0, 0);
        check_period("R1 no zero time", 20, 4, 12, 8, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_saturate();
        check_period("R5 sum over period", 30, 5, 25, 20, 2, 0, 0, 0, 0, 0);
        check_period("R5 tx over period", 30, 6, 50, 9, 2, 0, 0, 0, 0, 0);
        check_period("R4 short period", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_invalid();
        check_period("R3 sector 0", 24, 0, 8, 8, 2, 0, 0, 0, 0, 0);
        check_period("R3 sector 7", 24, 7, 8, 8, 2, 0, 0, 0, 0, 0);
    endtask

    task automatic t_dead();
        check_period("R9 dead 0", 32, 2, 10, 10, 0, 0, 0, 0, 0, 0);
        check_period("R9 dead 5", 60, 1, 20, 16, 5, 0, 0, 0, 0, 0);
    endtask

    task automatic t_latch();
        check_period("R4 mid-period change", 36, 2, 10, 6, 2, 1, 24, 5, 4, 8);
        check_period("R4 new config", 24, 5, 4, 8, 2, 0, 0, 0, 0, 0);
    endtask

    task automatic t_fault();
        int starts;
        apply(30, 1, 10, 8, 2);
        wait_start(); wait_start();
        repeat (7) @(negedge clk);
        fault = 1'b1;
        starts = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            check("R10 fault gates", {g_ser, g_hi, g_lo, g_odd, g_even}, 9'b0);
            if (cycle_start) starts++;
        end
        n_chk++;
        if (starts != 1) begin
            n_bad++;
            $display("FAIL R10 timing during fault: actual %0d starts expected 1", starts);
        end
        fault = 1'b0;
        check_period("R10 after fault", 30, 1, 10, 8, 2, 0, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_sectors();
        t_remainder();
        t_saturate();
        t_invalid();
        t_dead();
        t_latch();
        t_fault();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule